// File: doc/BRIEF.md
# Load Diagnostic Start-Up Sequencer

This controller runs a DC load check on a multi-channel amplifier (two channels by default) before the amplifier is allowed to run. On an accepted start request it raises the detection-enable control bit and holds it until the amplifier reports that the detection cycle has finished. The cycle also ends if a supply fault occurs or if an internal timeout expires. After every cycle it writes the enable bit back to 0 for one cycle. This cleanup write frees an amplifier that has hung. A cycle is counted as good only when the status valid flag reads 1 and no supply fault happened in that cycle.

A cycle that is not good is retried, up to a configurable number of attempts. When that number is used up, an error flag is raised. A configuration input then picks one of two actions: release the amplifier with no detection result, or clear the attempt counter and keep looping. Once the amplifier is released and reports that it is in operating mode, the controller reads the per-channel overcurrent bits. It combines them with the latched DC-load bits, publishes a 2-bit classification per channel and pulses done. The register bus transport is modelled by level and strobe signals.

States:
- `S_IDLE`: waits for a start request.
- `S_DETECT`: the enable bit is high.
- `S_CLEAN`: the enable bit is written back to 0.
- `S_RUN`: the amplifier is released and the controller waits for operating mode.
- `S_REPORT`: the done pulse.

Transitions:
- `S_IDLE` → `S_DETECT`: a start request arrives while both channel enables read 0.
- `S_DETECT` → `S_CLEAN`: the cycle finishes, a supply fault occurs or the timeout expires.
- `S_CLEAN` → `S_RUN`: the cycle was good, or the limit is reached with release mode selected.
- `S_CLEAN` → `S_DETECT`: retry.
- `S_RUN` → `S_REPORT`: operating mode is reported.
- `S_REPORT` → `S_IDLE`: always.

Top module: `lds_seq`

## Requirements
- R1: After reset, `det_en`, `amp_release`, `done` and `limit_err` are 0 and `load_codes` is all zero.
- R2: A start request is accepted only in `S_IDLE` while `amp_en_rb` is all zero. Otherwise it is ignored and `det_en` stays 0.
- R3: `det_en` goes high the cycle after an accepted start. It stays high until `cyc_done` or `supply_fault` is sampled, or for exactly `TMO_CYC` cycles if neither arrives.
- R4: After every detection cycle `det_en` is 0 for exactly one cycle (the cleanup write) before detection restarts or the amplifier is released.
- R5: A good cycle (`cyc_done` with `stat_valid`=1 and no `supply_fault`) leads directly to `amp_release`=1. No further detection follows, and `det_en` is never high while `amp_release` is high.
- R6: A cycle that is not good is retried while fewer than `attempt_limit` attempts have been made. A limit of 0 behaves as 1. Supply faults and timeouts count as not good. The attempt counter is cleared on each accepted start.
- R7: When the limit is reached, `limit_err` is set. With `retry_mode`=0 the amplifier is released without detection, and `load_codes` reports 00 for every channel.
- R8: When the limit is reached with `retry_mode`=1, `limit_err` is set and stays set, the counter is cleared and detection restarts.
- R9: Channel i is reported in `load_codes[2i+1:2i]`, using its latched DC-load bit `stat_dc[i]` and its overcurrent bit `stat_ocp[i]`, the latter sampled with `op_ready`. The mapping is:
  - dc 0, ocp 0 → 01 (speaker)
  - dc 0, ocp 1 → 10 (shorted)
  - dc 1, ocp 0 → 11 (open)
  - dc 1, ocp 1 → 00 (unknown)
- R10: `done` is a one-cycle pulse in the cycle after `op_ready` is sampled in `S_RUN`. `load_codes` takes its new value in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Request to begin the sequence |
| retry_mode | input | 1 | Action after the limit: 0 release, 1 keep looping |
| attempt_limit | input | CNT_W | Maximum number of detection attempts |
| amp_en_rb | input | NCH | Read-back of the channel amplifier enables |
| cyc_done | input | 1 | Detection cycle finished strobe |
| supply_fault | input | 1 | Undervoltage or overvoltage event |
| stat_valid | input | 1 | Status valid flag, read with `cyc_done` |
| stat_dc | input | NCH | Per-channel DC-load result bits |
| stat_ocp | input | NCH | Per-channel overcurrent bits, read with `op_ready` |
| op_ready | input | 1 | Amplifier reports operating mode |
| det_en | output | 1 | Detection-enable control bit |
| amp_release | output | 1 | Permission for the amplifier to start |
| done | output | 1 | Classification complete pulse |
| load_codes | output | 2*NCH | Per-channel 2-bit classification |
| limit_err | output | 1 | Attempt limit reached |

## Verification
The embedded properties assume the following about the inputs:
- `attempt_limit` and `retry_mode` stay constant from an accepted start until the done pulse.
- Status bits are only meaningful in the cycle that `cyc_done` or `op_ready` strobes them.
- `op_ready` is raised only after `amp_release`.

The stimulus changes configuration only while the controller is idle. It holds each strobe for a single cycle, presents status together with its strobe and asserts `op_ready` only once release has been observed. The attempt-bound property checks the counter against the limit, so the stimulus must not move the limit mid-run.

// File: rtl/lds_pkg.sv
package lds_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DETECT,
        S_CLEAN,
        S_RUN,
        S_REPORT
    } seq_state_t;

    typedef enum logic [1:0] {
        LD_UNKNOWN = 2'b00,
        LD_SPEAKER = 2'b01,
        LD_SHORT   = 2'b10,
        LD_OPEN    = 2'b11
    } load_code_t;

endpackage

// File: rtl/lds_timeout.sv
module lds_timeout #(
    parameter int TMO_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(TMO_CYC + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == TW'(TMO_CYC - 1));

    AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < TW'(TMO_CYC)); // R3

endmodule

// File: rtl/lds_classify.sv
module lds_classify
    import lds_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0]   dc,
    input  logic [NCH-1:0]   ocp,
    output logic [2*NCH-1:0] codes
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        load_code_t c;
        always_comb begin
            unique case ({dc[g], ocp[g]})
                2'b00:   c = LD_SPEAKER;
                2'b01:   c = LD_SHORT;
                2'b10:   c = LD_OPEN;
                default: c = LD_UNKNOWN;
            endcase
        end
        assign codes[2*g +: 2] = c;
    end

endmodule

// File: rtl/lds_seq.sv
module lds_seq
    import lds_pkg::*;
#(
    parameter int NCH     = 2,
    parameter int CNT_W   = 4,
    parameter int TMO_CYC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req,
    input  logic               retry_mode,
    input  logic [CNT_W-1:0]   attempt_limit,
    input  logic [NCH-1:0]     amp_en_rb,
    input  logic               cyc_done,
    input  logic               supply_fault,
    input  logic               stat_valid,
    input  logic [NCH-1:0]     stat_dc,
    input  logic [NCH-1:0]     stat_ocp,
    input  logic               op_ready,
    output logic               det_en,
    output logic               amp_release,
    output logic               done,
    output logic [2*NCH-1:0]   load_codes,
    output logic               limit_err
);
    localparam int LW = CNT_W + 1;

    seq_state_t        state, nstate;
    logic [CNT_W-1:0]  attempts;
    logic              det_ok;
    logic              detected;
    logic [NCH-1:0]    dc_lat;
    logic [2*NCH-1:0]  cls_codes;
    logic              tmo_exp;
    logic [LW-1:0]     lim;
    logic              at_limit;
    logic              cycle_end;
    logic              cycle_ok;
    logic              accept;

    assign lim       = (attempt_limit == '0) ? LW'(1) : {1'b0, attempt_limit};
    assign at_limit  = ({1'b0, attempts} + LW'(1)) >= lim;
    assign cycle_end = cyc_done || supply_fault || tmo_exp;
    assign cycle_ok  = cyc_done && stat_valid && !supply_fault;
    assign accept    = (state == S_IDLE) && start_req && (amp_en_rb == '0);

    lds_timeout #(.TMO_CYC(TMO_CYC)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == S_DETECT),
        .expired (tmo_exp)
    );

    lds_classify #(.NCH(NCH)) u_cls (
        .dc    (dc_lat),
        .ocp   (stat_ocp),
        .codes (cls_codes)
    );

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:   if (accept) nstate = S_DETECT;
            S_DETECT: if (cycle_end) nstate = S_CLEAN;
            S_CLEAN: begin
                if (det_ok || (at_limit && !retry_mode)) nstate = S_RUN;
                else                                     nstate = S_DETECT;
            end
            S_RUN:    if (op_ready) nstate = S_REPORT;
            S_REPORT: nstate = S_IDLE;
            default:  nstate = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // registered results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            attempts    <= '0;
            det_ok      <= 1'b0;
            detected    <= 1'b0;
            dc_lat      <= '0;
            load_codes  <= '0;
            limit_err   <= 1'b0;
            amp_release <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (accept) begin
                    attempts    <= '0;
                    det_ok      <= 1'b0;
                    detected    <= 1'b0;
                    load_codes  <= '0;
                    limit_err   <= 1'b0;
                    amp_release <= 1'b0;
                end
                S_DETECT: if (cycle_end) begin
                    det_ok <= cycle_ok;
                    dc_lat <= stat_dc;
                end
                S_CLEAN: begin
                    if (det_ok) begin
                        detected    <= 1'b1;
                        amp_release <= 1'b1;
                    end else if (at_limit) begin
                        limit_err <= 1'b1;
                        if (retry_mode) begin
                            attempts <= '0;
                        end else begin
                            attempts    <= attempts + 1'b1;
                            amp_release <= 1'b1;
                        end
                    end else begin
                        attempts <= attempts + 1'b1;
                    end
                end
                S_RUN: if (op_ready) begin
                    load_codes <= detected ? cls_codes : '0;
                end
                default: ;
            endcase
        end
    end

    // state-decoded outputs
    always_comb begin
        det_en = (state == S_DETECT);
        done   = (state == S_REPORT);
    end

    AST_GATED_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && amp_en_rb != '0) |=> !det_en); // R2
    AST_CLEANUP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && cycle_end) |=> (!det_en && state == S_CLEAN)); // R4
    AST_QUIET_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        amp_release |-> !det_en); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DETECT) |-> ({1'b0, attempts} < lim)); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_err && state != S_IDLE) |=> limit_err); // R8
    AST_CODES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && !op_ready) |=> $stable(load_codes)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

endmodule

// File: tb/lds_seq_tb.sv
module lds_seq_tb;
    localparam int NCH = 2;
    localparam int TMO = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 1'b0;
    logic       retry_mode = 1'b0;
    logic [3:0] attempt_limit = 4'd3;
    logic [1:0] amp_en_rb = 2'b00;
    logic       cyc_done = 1'b0;
    logic       supply_fault = 1'b0;
    logic       stat_valid = 1'b0;
    logic [1:0] stat_dc = 2'b00;
    logic [1:0] stat_ocp = 2'b00;
    logic       op_ready = 1'b0;
    logic       det_en, amp_release, done, limit_err;
    logic [3:0] load_codes;

    int checks = 0;
    int errors = 0;
    int rises = 0;
    logic det_q = 1'b0;

    always #2 clk = ~clk;

    lds_seq #(.NCH(NCH), .CNT_W(4), .TMO_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .retry_mode(retry_mode),
        .attempt_limit(attempt_limit), .amp_en_rb(amp_en_rb), .cyc_done(cyc_done),
        .supply_fault(supply_fault), .stat_valid(stat_valid), .stat_dc(stat_dc),
        .stat_ocp(stat_ocp), .op_ready(op_ready), .det_en(det_en),
        .amp_release(amp_release), .done(done), .load_codes(load_codes),
        .limit_err(limit_err)
    );

    always @(posedge clk) begin
        if (det_en && !det_q) rises <= rises + 1;
        det_q <= det_en;
    end

    // {dc[1:0], ocp[1:0], expected codes[3:0]}
    localparam logic [7:0] VEC [0:3] = '{
        8'b00_00_0101,
        8'b01_10_1011,
        8'b11_11_0000,
        8'b10_01_1110
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
    endtask

    // ends one detection cycle; afterwards sits one cycle past the cleanup
    task automatic finish_cycle(input logic v, input logic [1:0] dc, input logic flt);
        cyc_done = !flt; supply_fault = flt; stat_valid = v; stat_dc = dc;
        @(negedge clk);
        cyc_done = 1'b0; supply_fault = 1'b0; stat_valid = 1'b0;
        chk("R4 cleanup write", det_en, 0);
        @(negedge clk);
    endtask

    task automatic operate(input logic [1:0] ocp, input logic [3:0] exp, input string tag);
        stat_ocp = ocp; op_ready = 1'b1;
        @(negedge clk);
        op_ready = 1'b0;
        chk("R10 done pulse", done, 1);
        chk(tag, load_codes, exp);
        @(negedge clk);
        chk("R10 done single cycle", done, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 det_en", det_en, 0);
        chk("R1 amp_release", amp_release, 0);
        chk("R1 done", done, 0);
        chk("R1 limit_err", limit_err, 0);
        chk("R1 load_codes", load_codes, 0);

        // vector walk: good cycle, then classification (R3 R5 R9)
        for (int i = 0; i < 4; i++) begin
            attempt_limit = 4'd3; retry_mode = 1'b0;
            do_start();
            chk("R3 det_en after start", det_en, 1);
            finish_cycle(1'b1, VEC[i][7:6], 1'b0);
            chk("R5 release after good cycle", amp_release, 1);
            chk("R5 no redetect", det_en, 0);
            operate(VEC[i][5:4], VEC[i][3:0], "R9 classification");
        end

        // R2 start ignored while a channel is enabled
        amp_en_rb = 2'b01;
        base = rises;
        do_start();
        repeat (4) @(negedge clk);
        chk("R2 start ignored", rises - base, 0);
        chk("R2 det_en low", det_en, 0);
        amp_en_rb = 2'b00;

        // R6/R7 retries then release without detection
        attempt_limit = 4'd3; retry_mode = 1'b0;
        base = rises;
        do_start();
        for (int k = 0; k < 3; k++) finish_cycle(1'b0, 2'b00, 1'b0);
        chk("R6 attempts made", rises - base, 3);
        chk("R7 limit_err", limit_err, 1);
        chk("R7 released", amp_release, 1);
        operate(2'b00, 4'b0000, "R7 codes unknown");

        // R6 counter cleared on start
        attempt_limit = 4'd2;
        do_start();
        finish_cycle(1'b0, 2'b00, 1'b0);
        finish_cycle(1'b1, 2'b00, 1'b0);
        chk("R6 counter reset no error", limit_err, 0);
        operate(2'b00, 4'b0101, "R6 codes");

        // R3 timeout length
        attempt_limit = 4'd1;
        do_start();
        n = 0;
        while (det_en && n < 100) begin n++; @(negedge clk); end
        chk("R3 timeout cycles", n, TMO);
        chk("R4 cleanup after timeout", det_en, 0);
        @(negedge clk);
        chk("R6 timeout invalid", limit_err, 1);
        operate(2'b00, 4'b0000, "R7 codes after timeout");

        // R6 supply fault counts as invalid
        attempt_limit = 4'd2;
        base = rises;
        do_start();
        finish_cycle(1'b1, 2'b00, 1'b1);
        chk("R6 retry after fault", det_en, 1);
        finish_cycle(1'b1, 2'b00, 1'b0);
        chk("R6 fault attempts", rises - base, 2);
        chk("R6 no error", limit_err, 0);
        operate(2'b00, 4'b0101, "R9 codes after fault");

        // R8 keep looping
        attempt_limit = 4'd2; retry_mode = 1'b1;
        base = rises;
        do_start();
        finish_cycle(1'b0, 2'b00, 1'b0);
        finish_cycle(1'b0, 2'b00, 1'b0);
        chk("R8 limit_err", limit_err, 1);
        chk("R8 detect again", det_en, 1);
        finish_cycle(1'b0, 2'b00, 1'b0);
        finish_cycle(1'b1, 2'b00, 1'b0);
        chk("R8 attempts", rises - base, 4);
        chk("R8 released", amp_release, 1);
        operate(2'b10, 4'b1001, "R8 codes");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule